// File: doc/BRIEF.md
# Reloadable Event Down Counter

A 16-bit down counter that takes one step for each qualifying event and restarts from a reload register when it passes zero. The event comes from one of two places. One is a selectable transition on an external pin, which is first brought into the clock domain. The other is a one-cycle pulse from a neighbouring timer that has wrapped. Each wrap sets an interrupt request flag and emits a one-cycle pulse, so a further counter can be chained behind this one.

A single write port serves both the counter and the reload register. Where a write lands depends on the run bit. With the counter halted, a write presets the counter and the reload value together. With the counter running, a write changes only the reload value, and the counter picks it up at its next wrap. The count output always shows the live counter, never the reload register.

Top module: `evt_down_counter`

## Requirements
- R1: After reset, the counter output is 0000h, the reload register is 0000h (a later wrap loads 0000h), the interrupt flag is 0 and the wrap pulse is 0.
- R2: A write with runBit=0 sets both the counter and the reload register to wrData from the next clock edge. A write with runBit=1 changes only the reload register. The counter output keeps tracking the live count, and the new value first appears at the next wrap.
- R3: The counter steps only while runBit=1 and modeSel=01b. With runBit=0, or with any other modeSel code, events are ignored and the counter holds its value.
- R4: With srcSel=1, each clock cycle in which chainPulse is high is one event. With srcSel=0, events come from the external pin, and chainPulse is ignored.
- R5: edgeSel picks the active pin transition: 00b falling, 01b rising, 10b both, 11b none. The pin passes through two synchroniser flops. A change on the pin set up before clock edge k moves the counter at edge k+2.
- R6: Each event on a nonzero counter decrements it by one. An event at 0000h loads the reload value instead. With reload value n, a wrap happens every n+1 events, including n=0.
- R7: irqFlag is set by every wrap and stays set until irqAck or irqClear is high for a cycle. When a wrap and a clear fall in the same cycle, the flag stays set.
- R8: ufPulse is high for exactly the one cycle that follows the clock edge at which a wrap reloads the counter.
- R9: When an event and a running-mode write fall in the same cycle, the event uses the reload value held before the write, and the written value is used at the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 1 | Asynchronous external event pin |
| chainPulse | input | 1 | Wrap pulse from a neighbouring timer |
| modeSel | input | 2 | Timer mode; 01b enables event counting |
| srcSel | input | 1 | 0: external pin, 1: chained pulse |
| edgeSel | input | 2 | Pin edge: 00b fall, 01b rise, 10b both, 11b none |
| runBit | input | 1 | 1 runs the counter, 0 halts it |
| wrEn | input | 1 | Write strobe for the timer value |
| wrData | input | 16 | Write data |
| irqAck | input | 1 | Interrupt acknowledge, clears the flag |
| irqClear | input | 1 | Software clear of the flag |
| cntOut | output | 16 | Live counter value |
| irqFlag | output | 1 | Interrupt request flag |
| ufPulse | output | 1 | One-cycle wrap pulse for chaining |

## Verification
The bound checker watches several rules on every cycle. It checks the halted-write preset, that a running write leaves the count alone, that the count holds when halted or in the wrong mode, the single-step decrement, that a wrap happens only at zero, and the link between the interrupt flag and the wrap pulse. Some behaviour shows only in the bench scenarios. That covers the edge-select decoding through the synchroniser latency, the routing of the source select, the n+1 event period, a running write that arrives later at a wrap, and the same-cycle collision of event, write and clear.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

  localparam logic [1:0] MODE_EVENT = 2'b01;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edgeSel_e;

  // Strobes passed from control to datapath, one cycle each
  typedef struct packed {
    logic decr;        // step counter down by one
    logic reloadCnt;   // wrap: counter takes the reload value
    logic loadBoth;    // halted write: counter and reload
    logic loadReload;  // running write: reload only
    logic setIrq;      // raise interrupt flag
    logic clrIrq;      // drop interrupt flag
  } cntStrobes_t;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseEv,
  output logic fallEv
);

  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[STAGES-1];
  end

  assign riseEv =  syncQ[STAGES-1] & ~lastQ;
  assign fallEv = ~syncQ[STAGES-1] &  lastQ;

endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_cnt_pkg::*;
(
  input  logic [1:0]  modeSel,
  input  logic        srcSel,
  input  logic [1:0]  edgeSel,
  input  logic        runBit,
  input  logic        wrEn,
  input  logic        chainPulse,
  input  logic        riseEv,
  input  logic        fallEv,
  input  logic        cntZero,
  input  logic        irqAck,
  input  logic        irqClear,
  output cntStrobes_t strobes
);

  logic extEv;
  logic srcEv;
  logic counting;
  logic evtQual;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      EDGE_FALL: extEv = fallEv;
      EDGE_RISE: extEv = riseEv;
      EDGE_BOTH: extEv = riseEv | fallEv;
      default:   extEv = 1'b0;
    endcase
    srcEv    = srcSel ? chainPulse : extEv;
    counting = runBit && (modeSel == MODE_EVENT);
    evtQual  = counting && srcEv;

    strobes.decr       = evtQual && !cntZero;
    strobes.reloadCnt  = evtQual && cntZero;
    strobes.setIrq     = evtQual && cntZero;
    strobes.loadBoth   = wrEn && !runBit;
    strobes.loadReload = wrEn && runBit;
    strobes.clrIrq     = irqAck || irqClear;
  end

endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntZero,
  output logic             irqFlag,
  output logic             ufPulse
);

  logic [CNT_W-1:0] reloadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strobes.loadBoth || strobes.loadReload) begin
      reloadQ <= wrData;
    end
  end

  // Halted write wins; a running write never reaches the counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.loadBoth) begin
      cntQ <= wrData;
    end else if (strobes.reloadCnt) begin
      cntQ <= reloadQ;
    end else if (strobes.decr) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  // A new request outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      ufPulse <= 1'b0;
    end else begin
      ufPulse <= strobes.reloadCnt;
      if (strobes.setIrq)      irqFlag <= 1'b1;
      else if (strobes.clrIrq) irqFlag <= 1'b0;
    end
  end

  assign cntZero = (cntQ == '0);

endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             chainPulse,
  input  logic [1:0]       modeSel,
  input  logic             srcSel,
  input  logic [1:0]       edgeSel,
  input  logic             runBit,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             irqAck,
  input  logic             irqClear,
  output logic [CNT_W-1:0] cntOut,
  output logic             irqFlag,
  output logic             ufPulse
);

  cntStrobes_t strobes;
  logic        riseEv;
  logic        fallEv;
  logic        cntZero;

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (extPin),
    .riseEv (riseEv),
    .fallEv (fallEv)
  );

  evt_ctrl u_ctrl (
    .modeSel    (modeSel),
    .srcSel     (srcSel),
    .edgeSel    (edgeSel),
    .runBit     (runBit),
    .wrEn       (wrEn),
    .chainPulse (chainPulse),
    .riseEv     (riseEv),
    .fallEv     (fallEv),
    .cntZero    (cntZero),
    .irqAck     (irqAck),
    .irqClear   (irqClear),
    .strobes    (strobes)
  );

  evt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .cntQ    (cntOut),
    .cntZero (cntZero),
    .irqFlag (irqFlag),
    .ufPulse (ufPulse)
  );

endmodule

// File: rtl/evt_down_counter_chk.sv
module evt_down_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runBit,
  input logic [1:0]       modeSel,
  input logic             wrEn,
  input logic [CNT_W-1:0] wrData,
  input logic             irqAck,
  input logic             irqClear,
  input logic [CNT_W-1:0] cntOut,
  input logic             irqFlag,
  input logic             ufPulse,
  input logic             decr,
  input logic             reloadCnt
);

  // R2
  stopped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && wrEn) |=> (cntOut == $past(wrData)));

  // R2
  running_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && wrEn && !decr && !reloadCnt) |=> $stable(cntOut));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(runBit && modeSel == 2'b01) && !wrEn) |=> $stable(cntOut));

  // R6
  decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    decr |=> (cntOut == $past(cntOut) - 1'b1));

  // R6
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadCnt |-> (cntOut == '0));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ufPulse);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqAck || irqClear) && !reloadCnt) |=> !irqFlag);

  // R8
  uf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ufPulse |-> irqFlag);

endmodule

bind evt_down_counter evt_down_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .runBit    (runBit),
  .modeSel   (modeSel),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .irqAck    (irqAck),
  .irqClear  (irqClear),
  .cntOut    (cntOut),
  .irqFlag   (irqFlag),
  .ufPulse   (ufPulse),
  .decr      (strobes.decr),
  .reloadCnt (strobes.reloadCnt)
);

// File: tb/evt_down_counter_tb.sv
`timescale 1ns/1ps
module evt_down_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extPin = 1'b0;
  logic        chainPulse = 1'b0;
  logic [1:0]  modeSel = 2'b01;
  logic        srcSel = 1'b1;
  logic [1:0]  edgeSel = 2'b00;
  logic        runBit = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        irqAck = 1'b0;
  logic        irqClear = 1'b0;
  logic [15:0] cntOut;
  logic        irqFlag;
  logic        ufPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  evt_down_counter u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .chainPulse(chainPulse),
    .modeSel(modeSel), .srcSel(srcSel), .edgeSel(edgeSel), .runBit(runBit),
    .wrEn(wrEn), .wrData(wrData), .irqAck(irqAck), .irqClear(irqClear),
    .cntOut(cntOut), .irqFlag(irqFlag), .ufPulse(ufPulse)
  );

  // op codes: 0 write, 1 run, 2 chain pulses, 3 config, 4 pin toggles, 5 ack, 6 sw clear
  // config arg: [5:4] modeSel, [3] srcSel, [1:0] edgeSel
  localparam int NVEC = 30;
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd0, 16'h0005, 16'h0005, 1'b0},  // halted write presets counter
    {4'd1, 16'h0001, 16'h0005, 1'b0},  // start
    {4'd2, 16'h0003, 16'h0002, 1'b0},  // R4 chained source
    {4'd2, 16'h0002, 16'h0000, 1'b0},
    {4'd2, 16'h0001, 16'h0005, 1'b1},  // 6th event wraps
    {4'd5, 16'h0000, 16'h0005, 1'b0},
    {4'd0, 16'h0009, 16'h0005, 1'b0},  // running write: reload only
    {4'd2, 16'h0006, 16'h0009, 1'b1},  // wrap picks new reload
    {4'd6, 16'h0000, 16'h0009, 1'b0},
    {4'd1, 16'h0000, 16'h0009, 1'b0},  // halt
    {4'd2, 16'h0004, 16'h0009, 1'b0},  // ignored while halted
    {4'd0, 16'h0003, 16'h0003, 1'b0},
    {4'd3, 16'h0010, 16'h0003, 1'b0},  // pin source, falling edge
    {4'd1, 16'h0001, 16'h0003, 1'b0},
    {4'd4, 16'h0004, 16'h0001, 1'b0},  // two falls
    {4'd3, 16'h0011, 16'h0001, 1'b0},  // rising edge
    {4'd4, 16'h0002, 16'h0000, 1'b0},
    {4'd3, 16'h0012, 16'h0000, 1'b0},  // both edges
    {4'd4, 16'h0002, 16'h0002, 1'b1},  // wrap to 3, then 2
    {4'd6, 16'h0000, 16'h0002, 1'b0},
    {4'd3, 16'h0013, 16'h0002, 1'b0},  // no edge
    {4'd4, 16'h0003, 16'h0002, 1'b0},
    {4'd3, 16'h0008, 16'h0002, 1'b0},  // wrong mode, chained
    {4'd2, 16'h0002, 16'h0002, 1'b0},
    {4'd3, 16'h0018, 16'h0002, 1'b0},
    {4'd2, 16'h0002, 16'h0000, 1'b0},
    {4'd0, 16'h0000, 16'h0000, 1'b0},  // reload zero while running
    {4'd2, 16'h0001, 16'h0000, 1'b1},  // n=0 wraps each event
    {4'd2, 16'h0001, 16'h0000, 1'b1},
    {4'd5, 16'h0000, 16'h0000, 1'b0}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R6";
      4'd3: return "R3";
      4'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doChain(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); chainPulse = 1'b1;
      @(negedge clk); chainPulse = 1'b0;
    end
  endtask

  task automatic doToggle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); extPin = ~extPin;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cntOut == 16'h0 && !irqFlag && !ufPulse, "R1", "reset state",
          {15'd0, ufPulse, irqFlag, cntOut}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  op;
      logic [15:0] arg;
      op  = VEC[i][36:33];
      arg = VEC[i][32:17];
      case (op)
        4'd0: doWrite(arg);
        4'd1: begin @(negedge clk); runBit = arg[0]; @(negedge clk); end
        4'd2: doChain(int'(arg));
        4'd3: begin
          @(negedge clk);
          modeSel = arg[5:4]; srcSel = arg[3]; edgeSel = arg[1:0];
          @(negedge clk);
        end
        4'd4: doToggle(int'(arg));
        4'd5: begin @(negedge clk); irqAck = 1'b1; @(negedge clk); irqAck = 1'b0; end
        default: begin @(negedge clk); irqClear = 1'b1; @(negedge clk); irqClear = 1'b0; end
      endcase
      check(cntOut == VEC[i][16:1] && irqFlag == VEC[i][0], reqOf(op),
            $sformatf("vector %0d cnt/irq", i),
            {15'd0, irqFlag, cntOut}, {15'd0, VEC[i][0], VEC[i][16:1]});
    end

    // R8 wrap pulse lasts one cycle after the reload edge
    doWrite(16'h0007);
    @(negedge clk); chainPulse = 1'b1;
    @(negedge clk); chainPulse = 1'b0;
    check(cntOut == 16'h0007 && ufPulse && irqFlag, "R8", "wrap pulse high",
          {15'd0, ufPulse, cntOut}, {15'd1, 16'h0007});
    @(negedge clk);
    check(!ufPulse, "R8", "wrap pulse drops", {31'd0, ufPulse}, 32'd0);

    // R9 event and running write in one cycle; R7 set beats ack
    doWrite(16'h0002);
    doChain(7);
    check(cntOut == 16'h0000, "R6", "count to zero", {16'd0, cntOut}, 32'd0);
    @(negedge clk); chainPulse = 1'b1; wrEn = 1'b1; wrData = 16'h0055; irqAck = 1'b1;
    @(negedge clk); chainPulse = 1'b0; wrEn = 1'b0; irqAck = 1'b0;
    check(cntOut == 16'h0002, "R9", "old reload used", {16'd0, cntOut}, 32'h2);
    check(irqFlag == 1'b1, "R7", "set wins over ack", {31'd0, irqFlag}, 32'd1);
    doChain(3);
    check(cntOut == 16'h0055, "R9", "new reload at next wrap", {16'd0, cntOut}, 32'h55);

    // R2 halted write presets counter and reload together
    @(negedge clk); runBit = 1'b0;
    doWrite(16'h0001);
    @(negedge clk); runBit = 1'b1;
    doChain(2);
    check(cntOut == 16'h0001, "R2", "halted write also sets reload",
          {16'd0, cntOut}, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule